// File: doc/BRIEF.md
# I2C Channel Transaction Sequence Controller

This block is the per-channel state machine of a buffered I2C master. It sits between a host control register and a byte-level bus engine. The host writes three control bits: start, stop and stop-after-sequence. The controller then drives the engine with single-cycle command pulses: bus START, bus STOP, move one byte, and run the acknowledge phase. When it commands an acknowledge phase for a read, it also says whether that phase is an ACK or a NACK. The engine reports each finished phase back with a one-cycle event. Bit timing, the data buffer and host bus decoding are handled elsewhere.

A frame is a START followed by `frame_len` bytes. The mode, the direction and the frame length are captured when the channel starts. There are three modes. Single-shot mode runs one frame. Refresh-loop mode runs a frame, sends STOP and waits for a refresh tick before the next frame. Trigger-loop mode keeps the bus between frames and begins each new frame with a repeated START when the trigger input pulses.

A stop request from the host can end the transfer in one of three ways, depending on the channel state and the mode:
- at once;
- at the next byte boundary, with reads and writes treated differently;
- at the end of the current frame.

A request-driven stop sets the stop-done flag. In the loop modes it also sets the frame-loop-done flag. A byte counter reports how many bytes of the latest frame completed.

Top module: `i2c_seq_ctrl`

## Requirements
- R1: After reset all command outputs are 0, `busy` and `loop_idle` are 0, both status flags are 0 and `byte_cnt` is 0.
- R2: When the channel is inactive, a control write with sta=1 and sto=0 does the following: clears both status flags, captures the configuration, pulses `cmd_start`, and then runs `frame_len` byte cycles. Each byte cycle is a `cmd_byte` pulse after `ev_start_done` or after the previous `ev_ack_done`, then a `cmd_ack` pulse after `ev_byte_done`. At most one command pulses per cycle. An inactive write with sta=0, or with sto=1, issues no command and leaves `busy` at 0.
- R3: In single-shot mode (mode 2'b00, and also 2'b11), the frame's last `ev_ack_done` is followed by `cmd_stop`. After `ev_stop_done` the channel is inactive and the flags are left unchanged. For reads (`dir_rd`=1), `cmd_nack` is 1 only on the acknowledge of the frame's last byte. For writes it is always 0. `byte_cnt` equals `frame_len`.
- R4: A write with sta=1 while the channel is busy is ignored, and the command sequence is unchanged.
- R5: A sto=1 write during an active read makes the next byte received after the write get a NACK. After that byte's `ev_ack_done`, `cmd_stop` follows.
- R6: A sto=1 write during an active write makes `cmd_stop` follow the `ev_ack_done` of the byte in progress.
- R7: When a stop caused by sto ends, the channel goes inactive and `stat_sd` is set. In the loop modes `stat_fld` is also set. `byte_cnt` holds the number of bytes whose acknowledge phase completed in the frame.
- R8: In refresh-loop mode (2'b01), each frame ends with `cmd_stop`, after which `loop_idle` is 1 and no command is issued until `refresh_tick`, which gives `cmd_start`. A stopseq=1 write during a frame lets the frame finish with its STOP, then sets SD and FLD and goes inactive.
- R9: In refresh-loop mode with `loop_idle`=1, a write with sto=1 or stopseq=1 makes the channel inactive on the next cycle and sets SD and FLD, with no bus command.
- R10: In trigger-loop mode (2'b10), a frame ends without STOP into `loop_idle`, and `trigger` gives a repeated `cmd_start`. A stopseq=1 write there gives `cmd_stop`, then SD and FLD, then the inactive state. A stopseq=1 write during a frame gives `cmd_stop` after the frame's last byte.
- R11: A write with both sto and stopseq set is handled as a sto write.
- R12: In single-shot mode a stopseq=1 write has no effect: the frame runs to its end and the flags stay 0.
- R13: A one-cycle `stat_clr` pulse clears both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sta | input | 1 | Start request bit |
| ctl_sto | input | 1 | Stop request bit |
| ctl_stopseq | input | 1 | Stop-after-sequence request bit |
| stat_clr | input | 1 | Host clear of both status flags |
| mode | input | 2 | 00 single, 01 refresh loop, 10 trigger loop, 11 single |
| dir_rd | input | 1 | 1 = read transaction, 0 = write |
| frame_len | input | LEN_W | Bytes per frame (0 treated as 1) |
| refresh_tick | input | 1 | Starts the next frame in refresh-loop mode |
| trigger | input | 1 | Starts the next frame in trigger-loop mode |
| ev_start_done | input | 1 | Engine finished START |
| ev_byte_done | input | 1 | Engine finished the data bits of a byte |
| ev_ack_done | input | 1 | Engine finished the acknowledge phase |
| ev_stop_done | input | 1 | Engine finished STOP |
| cmd_start | output | 1 | Issue START or repeated START |
| cmd_stop | output | 1 | Issue STOP |
| cmd_byte | output | 1 | Move the next byte |
| cmd_ack | output | 1 | Run the acknowledge phase |
| cmd_nack | output | 1 | With cmd_ack on reads: answer NACK |
| busy | output | 1 | Channel is not inactive |
| loop_idle | output | 1 | Between frames in a loop mode |
| stat_sd | output | 1 | Stop-done flag |
| stat_fld | output | 1 | Frame-loop-done flag |
| byte_cnt | output | LEN_W | Bytes completed in the latest frame |

## Verification
Each engine event is answered with a registered command one cycle later. A wrong internal state therefore shows up within one engine round trip as a command that is missing, extra, out of order or carries the wrong NACK. A request that is lost or acts too early changes the length of the command trace, and that shows in the final `byte_cnt`. Flag errors are visible on `stat_sd` and `stat_fld` in the cycle after the channel goes inactive. A refresh-loop immediate stop must show `busy` low on the cycle right after the write.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE    = 2'b00,
        MODE_REFRESH = 2'b01,
        MODE_TRIGGER = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        ST_INACT,
        ST_START,
        ST_BYTE,
        ST_ACK,
        ST_STOP,
        ST_LIDLE
    } state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic byte_go;
        logic ack_go;
        logic nack;
    } cmd_t;

    localparam cmd_t CMD_NONE = '{default: 1'b0};

    function automatic mode_e mode_decode(input logic [1:0] m);
        case (m)
            2'b01:   return MODE_REFRESH;
            2'b10:   return MODE_TRIGGER;
            default: return MODE_ONCE;
        endcase
    endfunction

    function automatic logic mode_loops(input mode_e m);
        return (m == MODE_REFRESH) || (m == MODE_TRIGGER);
    endfunction

    function automatic logic state_tracks(input state_e s);
        return (s == ST_START) || (s == ST_BYTE) || (s == ST_ACK) || (s == ST_STOP);
    endfunction

endpackage

// File: rtl/seqc_byte_cnt.sv
module seqc_byte_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             last
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] cnt_q;
    logic [CW-1:0]    nxt_wide;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign nxt_wide = {1'b0, cnt_q} + CW'(1);
    assign last     = (nxt_wide >= {1'b0, len});
    assign cnt      = cnt_q;

    // R7: the count only steps up by one or restarts from zero
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + LEN_W'(1)) || (cnt_q == '0)));

endmodule

// File: rtl/seqc_req_track.sv
module seqc_req_track (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic sto,
    input  logic stopseq,
    input  logic loop_en,
    input  logic nack_mark,
    input  logic clear,
    output logic sto_pend,
    output logic seq_pend,
    output logic nack_sto
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sto_pend <= 1'b0;
            seq_pend <= 1'b0;
            nack_sto <= 1'b0;
        end else begin
            if (wr && sto) begin
                sto_pend <= 1'b1;
            end
            if (wr && !sto && stopseq && loop_en) begin
                seq_pend <= 1'b1;
            end
            if (nack_mark) begin
                nack_sto <= 1'b1;
            end
        end
    end

    // R12: a frame-end stop request only exists in a loop mode
    assert_seqpend_loop_R12: assert property (@(posedge clk) disable iff (rst)
        seq_pend |-> loop_en);

    // R11: a write with both bits never arms the frame-end request
    assert_sto_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (wr && sto && stopseq && !seq_pend && !clear) |=> !seq_pend);

endmodule

// File: rtl/seqc_status.sv
module seqc_status (
    input  logic clk,
    input  logic rst,
    input  logic set_sd,
    input  logic set_fld,
    input  logic clr,
    output logic sd,
    output logic fld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sd  <= 1'b0;
            fld <= 1'b0;
        end else begin
            if (set_sd) begin
                sd <= 1'b1;
            end else if (clr) begin
                sd <= 1'b0;
            end
            if (set_fld) begin
                fld <= 1'b1;
            end else if (clr) begin
                fld <= 1'b0;
            end
        end
    end

    // R7: frame-loop-done never appears without stop-done
    assert_fld_has_sd_R7: assert property (@(posedge clk) disable iff (rst)
        fld |-> sd);

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_sta,
    input  logic             ctl_sto,
    input  logic             ctl_stopseq,
    input  logic             stat_clr,
    input  logic [1:0]       mode,
    input  logic             dir_rd,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             refresh_tick,
    input  logic             trigger,
    input  logic             ev_start_done,
    input  logic             ev_byte_done,
    input  logic             ev_ack_done,
    input  logic             ev_stop_done,
    output logic             cmd_start,
    output logic             cmd_stop,
    output logic             cmd_byte,
    output logic             cmd_ack,
    output logic             cmd_nack,
    output logic             busy,
    output logic             loop_idle,
    output logic             stat_sd,
    output logic             stat_fld,
    output logic [LEN_W-1:0] byte_cnt
);
    import seqc_pkg::*;

    state_e           st_q, st_d;
    cmd_t             cmd_q, cmd_d;
    logic             fin_q, fin_d;
    logic             flset_q, flset_d;
    mode_e            cfg_mode;
    logic             cfg_rd;
    logic [LEN_W-1:0] cfg_len;

    logic cfg_load, cnt_clr, cnt_inc, nack_mark, go_inact;
    logic set_sd, set_fld, start_clr;
    logic sto_pend, seq_pend, nack_sto, is_last, in_loop, wr_track, sto_cut;

    assign in_loop  = mode_loops(cfg_mode);
    assign wr_track = ctl_wr && state_tracks(st_q);
    assign sto_cut  = cfg_rd ? nack_sto : sto_pend;

    always_comb begin
        st_d      = st_q;
        cmd_d     = CMD_NONE;
        fin_d     = fin_q;
        flset_d   = flset_q;
        cfg_load  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        nack_mark = 1'b0;
        go_inact  = 1'b0;
        set_sd    = 1'b0;
        set_fld   = 1'b0;
        start_clr = 1'b0;
        case (st_q)
            ST_INACT: begin
                if (ctl_wr && ctl_sta && !ctl_sto) begin
                    cfg_load    = 1'b1;
                    start_clr   = 1'b1;
                    cnt_clr     = 1'b1;
                    fin_d       = 1'b0;
                    flset_d     = 1'b0;
                    cmd_d.start = 1'b1;
                    st_d        = ST_START;
                end
            end
            ST_START: begin
                if (ev_start_done) begin
                    cmd_d.byte_go = 1'b1;
                    st_d          = ST_BYTE;
                end
            end
            ST_BYTE: begin
                if (ev_byte_done) begin
                    cmd_d.ack_go = 1'b1;
                    cmd_d.nack   = cfg_rd && (is_last || sto_pend);
                    nack_mark    = cfg_rd && sto_pend;
                    st_d         = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ev_ack_done) begin
                    cnt_inc = 1'b1;
                    if (sto_cut || (is_last && sto_pend)) begin
                        cmd_d.stop = 1'b1;
                        fin_d      = 1'b1;
                        flset_d    = 1'b1;
                        st_d       = ST_STOP;
                    end else if (is_last) begin
                        case (cfg_mode)
                            MODE_REFRESH: begin
                                cmd_d.stop = 1'b1;
                                fin_d      = seq_pend;
                                flset_d    = seq_pend;
                                st_d       = ST_STOP;
                            end
                            MODE_TRIGGER: begin
                                if (seq_pend) begin
                                    cmd_d.stop = 1'b1;
                                    fin_d      = 1'b1;
                                    flset_d    = 1'b1;
                                    st_d       = ST_STOP;
                                end else begin
                                    st_d = ST_LIDLE;
                                end
                            end
                            default: begin
                                cmd_d.stop = 1'b1;
                                fin_d      = 1'b1;
                                flset_d    = 1'b0;
                                st_d       = ST_STOP;
                            end
                        endcase
                    end else begin
                        cmd_d.byte_go = 1'b1;
                        st_d          = ST_BYTE;
                    end
                end
            end
            ST_STOP: begin
                if (ev_stop_done) begin
                    if (fin_q || (in_loop && (sto_pend || seq_pend))) begin
                        go_inact = 1'b1;
                        set_sd   = flset_q || !fin_q;
                        set_fld  = (flset_q || !fin_q) && in_loop;
                        st_d     = ST_INACT;
                    end else begin
                        st_d = ST_LIDLE;
                    end
                end
            end
            ST_LIDLE: begin
                if (ctl_wr && (ctl_sto || ctl_stopseq)) begin
                    if (cfg_mode == MODE_REFRESH) begin
                        go_inact = 1'b1;
                        set_sd   = 1'b1;
                        set_fld  = 1'b1;
                        st_d     = ST_INACT;
                    end else begin
                        cmd_d.stop = 1'b1;
                        fin_d      = 1'b1;
                        flset_d    = 1'b1;
                        st_d       = ST_STOP;
                    end
                end else if ((cfg_mode == MODE_REFRESH && refresh_tick) ||
                             (cfg_mode == MODE_TRIGGER && trigger)) begin
                    cmd_d.start = 1'b1;
                    cnt_clr     = 1'b1;
                    st_d        = ST_START;
                end
            end
            default: begin
                go_inact = 1'b1;
                st_d     = ST_INACT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_INACT;
            cmd_q    <= CMD_NONE;
            fin_q    <= 1'b0;
            flset_q  <= 1'b0;
            cfg_mode <= MODE_ONCE;
            cfg_rd   <= 1'b0;
            cfg_len  <= LEN_W'(1);
        end else begin
            st_q    <= st_d;
            cmd_q   <= cmd_d;
            fin_q   <= fin_d;
            flset_q <= flset_d;
            if (cfg_load) begin
                cfg_mode <= mode_decode(mode);
                cfg_rd   <= dir_rd;
                cfg_len  <= (frame_len == '0) ? LEN_W'(1) : frame_len;
            end
        end
    end

    seqc_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .len  (cfg_len),
        .cnt  (byte_cnt),
        .last (is_last)
    );

    seqc_req_track u_req (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_track),
        .sto       (ctl_sto),
        .stopseq   (ctl_stopseq),
        .loop_en   (in_loop),
        .nack_mark (nack_mark),
        .clear     (go_inact),
        .sto_pend  (sto_pend),
        .seq_pend  (seq_pend),
        .nack_sto  (nack_sto)
    );

    seqc_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_sd  (set_sd),
        .set_fld (set_fld),
        .clr     (stat_clr || start_clr),
        .sd      (stat_sd),
        .fld     (stat_fld)
    );

    assign cmd_start = cmd_q.start;
    assign cmd_stop  = cmd_q.stop;
    assign cmd_byte  = cmd_q.byte_go;
    assign cmd_ack   = cmd_q.ack_go;
    assign cmd_nack  = cmd_q.nack;
    assign busy      = (st_q != ST_INACT);
    assign loop_idle = (st_q == ST_LIDLE);

    // R2: the engine never sees two commands in one cycle
    assert_one_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_start, cmd_stop, cmd_byte, cmd_ack}));

    // R3: a NACK is only requested with an acknowledge phase of a read
    assert_nack_read_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_nack |-> (cmd_ack && cfg_rd));

    // R7: stop-done rises only as the channel becomes inactive
    assert_sd_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_sd) |-> !busy);

    // R9: an early stop between refresh frames is immediate
    assert_refresh_idle_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (loop_idle && cfg_mode == MODE_REFRESH && ctl_wr && (ctl_sto || ctl_stopseq))
        |=> (!busy && !cmd_stop));

    // R8: between frames no byte traffic is commanded
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        loop_idle |-> !(cmd_byte || cmd_ack));

endmodule

// File: tb/tb_i2c_seq_ctrl.sv
module tb_i2c_seq_ctrl;
    localparam int LEN_W = 8;
    localparam int K_START = 0, K_BYTE = 1, K_ACK0 = 2, K_ACK1 = 3, K_STOP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, ctl_sta = 0, ctl_sto = 0, ctl_stopseq = 0, stat_clr = 0;
    logic [1:0] mode = 2'b00;
    logic dir_rd = 0;
    logic [LEN_W-1:0] frame_len = 8'd1;
    logic refresh_tick = 0, trigger = 0;
    logic ev_start_done = 0, ev_byte_done = 0, ev_ack_done = 0, ev_stop_done = 0;
    logic cmd_start, cmd_stop, cmd_byte, cmd_ack, cmd_nack;
    logic busy, loop_idle, stat_sd, stat_fld;
    logic [LEN_W-1:0] byte_cnt;

    int errors = 0;
    int checks = 0;
    int n_byte = 0;
    int exp_k[$];
    string exp_t[$];

    always #2 clk = ~clk;

    i2c_seq_ctrl #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_sta(ctl_sta), .ctl_sto(ctl_sto),
        .ctl_stopseq(ctl_stopseq), .stat_clr(stat_clr), .mode(mode), .dir_rd(dir_rd),
        .frame_len(frame_len), .refresh_tick(refresh_tick), .trigger(trigger),
        .ev_start_done(ev_start_done), .ev_byte_done(ev_byte_done),
        .ev_ack_done(ev_ack_done), .ev_stop_done(ev_stop_done),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_byte(cmd_byte),
        .cmd_ack(cmd_ack), .cmd_nack(cmd_nack), .busy(busy), .loop_idle(loop_idle),
        .stat_sd(stat_sd), .stat_fld(stat_fld), .byte_cnt(byte_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic push(input int k, input string tag);
        exp_k.push_back(k);
        exp_t.push_back(tag);
    endtask

    task automatic push_frame(input int n, input bit rd, input string tag);
        push(K_START, tag);
        for (int i = 0; i < n; i++) begin
            push(K_BYTE, tag);
            push((rd && i == n - 1) ? K_ACK1 : K_ACK0, tag);
        end
    endtask

    task automatic ctl(input bit sta, input bit sto, input bit seq);
        @(negedge clk);
        ctl_wr = 1; ctl_sta = sta; ctl_sto = sto; ctl_stopseq = seq;
        @(negedge clk);
        ctl_wr = 0; ctl_sta = 0; ctl_sto = 0; ctl_stopseq = 0;
    endtask

    task automatic setup(input logic [1:0] m, input bit rd, input int n);
        mode = m; dir_rd = rd; frame_len = LEN_W'(n);
    endtask

    task automatic wait_done;
        do @(negedge clk); while (busy || exp_k.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_lidle;
        do @(negedge clk); while (!loop_idle || exp_k.size() != 0);
    endtask

    task automatic wait_bytes(input int base, input int k);
        while (n_byte < base + k) @(negedge clk);
    endtask

    // monitor: compares every command against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (cmd_start || cmd_stop || cmd_byte || cmd_ack)) begin
                int k;
                int n_on;
                n_on = int'(cmd_start) + int'(cmd_stop) + int'(cmd_byte) + int'(cmd_ack);
                if (n_on != 1) k = 9;
                else if (cmd_start) k = K_START;
                else if (cmd_byte) k = K_BYTE;
                else if (cmd_stop) k = K_STOP;
                else k = cmd_nack ? K_ACK1 : K_ACK0;
                if (cmd_byte) n_byte++;
                if (exp_k.size() == 0) begin
                    check(1'b0, "R2", "unexpected command", k, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_k.pop_front();
                    t = exp_t.pop_front();
                    check(k == e, t, "command kind", k, e);
                end
            end
        end
    end

    // engine model: answers each command four cycles later
    initial begin
        int cd;
        int kind;
        cd = 0;
        kind = 0;
        forever begin
            @(negedge clk);
            ev_start_done = 0; ev_byte_done = 0; ev_ack_done = 0; ev_stop_done = 0;
            if (rst) begin
                cd = 0;
            end else begin
                if (cd > 0) begin
                    cd--;
                    if (cd == 0) begin
                        case (kind)
                            K_START: ev_start_done = 1;
                            K_BYTE:  ev_byte_done = 1;
                            K_ACK0:  ev_ack_done = 1;
                            default: ev_stop_done = 1;
                        endcase
                    end
                end
                if (cmd_start) begin kind = K_START; cd = 4; end
                else if (cmd_byte) begin kind = K_BYTE; cd = 4; end
                else if (cmd_ack) begin kind = K_ACK0; cd = 4; end
                else if (cmd_stop) begin kind = K_STOP; cd = 4; end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !loop_idle, "R1", "busy/loop_idle", int'(busy), 0);
        check(!stat_sd && !stat_fld, "R1", "flags", int'(stat_sd), 0);
        check(byte_cnt == 0, "R1", "byte_cnt", int'(byte_cnt), 0);
        check(!(cmd_start || cmd_stop || cmd_byte || cmd_ack), "R1", "commands", 1, 0);

        // R2/R3 single write frame of 3
        setup(2'b00, 0, 3);
        push_frame(3, 0, "R2"); push(K_STOP, "R3");
        ctl(1, 0, 0);
        wait_done();
        check(byte_cnt == 3, "R3", "write byte_cnt", int'(byte_cnt), 3);
        check(!stat_sd && !stat_fld, "R3", "flags after plain end", int'(stat_sd), 0);

        // R3 single read frame of 3, last byte NACKed
        setup(2'b00, 1, 3);
        push_frame(3, 1, "R3"); push(K_STOP, "R3");
        ctl(1, 0, 0);
        wait_done();
        check(byte_cnt == 3, "R3", "read byte_cnt", int'(byte_cnt), 3);

        // R2 inactive writes that must not start
        ctl(0, 0, 0);
        ctl(0, 1, 1);
        ctl(1, 1, 0);
        repeat (20) @(negedge clk);
        check(!busy, "R2", "busy after ignored writes", int'(busy), 0);

        // R4 STA while busy
        setup(2'b00, 0, 2);
        push_frame(2, 0, "R4"); push(K_STOP, "R4");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 1);
        ctl(1, 0, 0);
        wait_done();
        check(byte_cnt == 2, "R4", "byte_cnt", int'(byte_cnt), 2);
        check(!stat_sd, "R4", "sd", int'(stat_sd), 0);

        // R6 STO during write of 4
        setup(2'b00, 0, 4);
        push_frame(2, 0, "R6"); push(K_STOP, "R6");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 2);
        ctl(0, 1, 0);
        wait_done();
        check(byte_cnt == 2, "R7", "byte_cnt after sto write", int'(byte_cnt), 2);
        check(stat_sd && !stat_fld, "R7", "sd set fld clear single", int'(stat_fld), 0);

        // R2 STA from inactive clears flags
        setup(2'b00, 0, 1);
        push_frame(1, 0, "R2"); push(K_STOP, "R2");
        ctl(1, 0, 0);
        @(negedge clk);
        check(!stat_sd, "R2", "sd cleared by start", int'(stat_sd), 0);
        wait_done();

        // R5 STO during read of 4: byte 2 NACKed
        setup(2'b00, 1, 4);
        push(K_START, "R5"); push(K_BYTE, "R5"); push(K_ACK0, "R5");
        push(K_BYTE, "R5"); push(K_ACK1, "R5"); push(K_STOP, "R5");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 2);
        ctl(0, 1, 0);
        wait_done();
        check(byte_cnt == 2, "R5", "byte_cnt after sto read", int'(byte_cnt), 2);
        check(stat_sd, "R7", "sd after sto read", int'(stat_sd), 1);

        // R13 host clear
        @(negedge clk); stat_clr = 1;
        @(negedge clk); stat_clr = 0;
        check(!stat_sd && !stat_fld, "R13", "flags after clear", int'(stat_sd), 0);

        // R8 refresh loop, stopseq during second frame
        setup(2'b01, 0, 2);
        push_frame(2, 0, "R8"); push(K_STOP, "R8");
        ctl(1, 0, 0);
        wait_lidle();
        repeat (10) @(negedge clk);
        check(busy && loop_idle, "R8", "waiting for tick", int'(loop_idle), 1);
        push_frame(2, 0, "R8"); push(K_STOP, "R8");
        base = n_byte;
        refresh_tick = 1; @(negedge clk); refresh_tick = 0;
        wait_bytes(base, 1);
        ctl(0, 0, 1);
        wait_done();
        check(stat_sd && stat_fld, "R8", "flags after stopseq", int'(stat_fld), 1);
        check(byte_cnt == 2, "R8", "byte_cnt", int'(byte_cnt), 2);

        // R9 refresh idle: sto, then stopseq
        for (int v = 0; v < 2; v++) begin
            setup(2'b01, 0, 1);
            push_frame(1, 0, "R9"); push(K_STOP, "R9");
            ctl(1, 0, 0);
            wait_lidle();
            ctl(0, v == 0, v == 1);
            check(!busy, "R9", "inactive at once", int'(busy), 0);
            check(stat_sd && stat_fld, "R9", "flags", int'(stat_fld), 1);
            repeat (10) @(negedge clk);
        end

        // R10 trigger loop, repeated start, stopseq in idle
        setup(2'b10, 1, 2);
        push_frame(2, 1, "R10");
        ctl(1, 0, 0);
        wait_lidle();
        repeat (10) @(negedge clk);
        check(busy && loop_idle, "R10", "holding bus", int'(loop_idle), 1);
        push_frame(2, 1, "R10");
        trigger = 1; @(negedge clk); trigger = 0;
        wait_lidle();
        push(K_STOP, "R10");
        ctl(0, 0, 1);
        wait_done();
        check(stat_sd && stat_fld, "R10", "flags after idle stopseq", int'(stat_fld), 1);
        check(byte_cnt == 2, "R10", "byte_cnt", int'(byte_cnt), 2);

        // R10 trigger stopseq during frame
        setup(2'b10, 0, 2);
        push_frame(2, 0, "R10"); push(K_STOP, "R10");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 1);
        ctl(0, 0, 1);
        wait_done();
        check(stat_sd && stat_fld, "R10", "flags after frame stopseq", int'(stat_fld), 1);

        // R7 trigger sto during read: first byte NACKed
        setup(2'b10, 1, 3);
        push(K_START, "R7"); push(K_BYTE, "R7"); push(K_ACK1, "R7"); push(K_STOP, "R7");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 1);
        ctl(0, 1, 0);
        wait_done();
        check(byte_cnt == 1, "R7", "byte_cnt trigger sto", int'(byte_cnt), 1);
        check(stat_sd && stat_fld, "R7", "loop flags", int'(stat_fld), 1);

        // R11 both bits in refresh frame act as sto
        setup(2'b01, 0, 4);
        push_frame(2, 0, "R11"); push(K_STOP, "R11");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 2);
        ctl(0, 1, 1);
        wait_done();
        check(byte_cnt == 2, "R11", "byte_cnt", int'(byte_cnt), 2);
        check(stat_sd && stat_fld, "R11", "flags", int'(stat_fld), 1);

        // R12 stopseq ignored in single mode
        setup(2'b00, 0, 3);
        push_frame(3, 0, "R12"); push(K_STOP, "R12");
        base = n_byte;
        ctl(1, 0, 0);
        wait_bytes(base, 1);
        ctl(0, 0, 1);
        wait_done();
        check(byte_cnt == 3, "R12", "byte_cnt", int'(byte_cnt), 3);
        check(!stat_sd && !stat_fld, "R12", "flags", int'(stat_sd), 0);

        repeat (10) @(negedge clk);
        check(exp_k.size() == 0, "R2", "commands still expected", exp_k.size(), 0);
        report();
        $finish;
    end

endmodule